// File: doc/BRIEF.md
# Dual-Clock Host Bus to Core Bridge

This block joins a host bus clock domain to a free-running core clock domain. The host side looks like a small memory: chip select, write enable, a 16-bit address, 32-bit write data and 32-bit read data, plus a stall output that tells the host to hold its access. Each access becomes a command word of a write flag, an address and data. The word crosses into the core domain through a shallow asynchronous FIFO with Gray-coded pointers. Read results travel back through a second FIFO of the same kind.

On the core side the bridge takes commands one at a time. A write becomes a single-cycle write strobe. A read becomes a single-cycle read strobe, and the core's read data is captured on the following cycle. The core domain does not depend on the host clock. It keeps draining queued commands while the host clock is stopped, because that clock toggles only while the host is making accesses. Each domain has its own active-high reset, which is synchronized locally. Asserting either reset input clears both sides.

Top module: `xdom_bus_bridge`

## Requirements
- R1: A host write (h_cs=1, h_we=1) that is present with h_stall low at a rising h_clk edge produces exactly one c_wr pulse. The pulse carries the same 16-bit address on c_addr and the same 32-bit data on c_wdata.
- R2: Commands execute on the core side in the order the host issued them. A read returns the value left by every earlier write to that address.
- R3: The command FIFO holds 4 entries. When it is full, h_stall is high during a host write and the write is held. The held write is accepted once space frees, and no write is lost or duplicated.
- R4: A host read (h_cs=1, h_we=0) keeps h_stall high from issue until its result is ready. After that, h_rvalid is high for exactly one h_clk cycle with h_stall low, and h_rdata equals the c_rdata value present on the c_clk cycle after the c_rd pulse.
- R5: c_rd lasts exactly one c_clk cycle, and c_wr and c_rd are never high together.
- R6: With h_clk stopped, the core side still executes every command that was already accepted.
- R7: Asserting h_rst or c_rst resets both domains. After release, c_wr, c_rd and h_rvalid are low, h_stall is low while h_cs is low, and commands queued before the reset are never executed.
- R8: Only one read is outstanding at a time. Each host read causes exactly one c_rd pulse, and no new access is taken until its h_rvalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| h_clk | input | 1 | Host bus clock; may stop between accesses |
| h_rst | input | 1 | Host-side reset, active high |
| h_cs | input | 1 | Host access select |
| h_we | input | 1 | 1 = write access, 0 = read access |
| h_addr | input | 16 | Host access address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Read result, valid with h_rvalid |
| h_rvalid | output | 1 | One-cycle read completion strobe |
| h_stall | output | 1 | Host must hold its access while high |
| c_clk | input | 1 | Free-running core clock |
| c_rst | input | 1 | Core-side reset, active high |
| c_wr | output | 1 | One-cycle core write strobe |
| c_rd | output | 1 | One-cycle core read strobe |
| c_addr | output | 16 | Core access address |
| c_wdata | output | 32 | Core write data |
| c_rdata | input | 32 | Core read data, sampled the cycle after c_rd |

## Verification
The bench stops the core clock to fill the command FIFO. A bridge with a wrong full compare would then either overwrite an unread entry, so a core write goes missing, or never raise the stall. Stopping the host clock while the core clock runs exposes any dependence of draining on host activity: the queued writes would never appear. A reset taken while commands sit in the FIFO catches stale pointers, which would replay discarded writes after release. Random mixes of reads and writes to a few colliding addresses catch ordering faults and capture-cycle slips, which show up as read data one write behind.

// File: rtl/xb_pkg.sv
`timescale 1ns/1ps
package xb_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    typedef enum logic [1:0] {
        H_IDLE   = 2'd0,
        H_RDWAIT = 2'd1,
        H_RDDONE = 2'd2
    } hstate_t;

    typedef enum logic [1:0] {
        C_IDLE  = 2'd0,
        C_RDSTB = 2'd1,
        C_RDCAP = 2'd2
    } cstate_t;

    function automatic cmd_t make_cmd(input logic wr,
                                      input logic [ADDR_W-1:0] addr,
                                      input logic [DATA_W-1:0] data);
        cmd_t c;
        c.wr   = wr;
        c.addr = addr;
        c.data = wr ? data : '0;
        return c;
    endfunction

endpackage

// File: rtl/xb_sync.sv
`timescale 1ns/1ps
module xb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/xb_afifo.sv
`timescale 1ns/1ps
module xb_afifo #(
    parameter int W      = 8,
    parameter int AW     = 2,
    parameter int STAGES = 2
) (
    input  logic         wclk,
    input  logic         wrst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    output logic         full,
    input  logic         rclk,
    input  logic         rrst,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wbin, wgray, wbin_nx, wgray_nx;
    logic [PW-1:0] rbin, rgray, rbin_nx, rgray_nx;
    logic [PW-1:0] rgray_w, wgray_r;

    assign wbin_nx  = wbin + PW'(1);
    assign wgray_nx = wbin_nx ^ (wbin_nx >> 1);
    assign rbin_nx  = rbin + PW'(1);
    assign rgray_nx = rbin_nx ^ (rbin_nx >> 1);

    always_ff @(posedge wclk) begin
        if (push && !full) mem[wbin[AW-1:0]] <= wdata;
    end

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (push && !full) begin
            wbin  <= wbin_nx;
            wgray <= wgray_nx;
        end
    end

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (pop && !empty) begin
            rbin  <= rbin_nx;
            rgray <= rgray_nx;
        end
    end

    xb_sync #(.W(PW), .STAGES(STAGES)) u_r2w (
        .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_w)
    );
    xb_sync #(.W(PW), .STAGES(STAGES)) u_w2r (
        .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_r)
    );

    generate
        if (PW > 2) begin : g_full_wide
            assign full = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
        end else begin : g_full_narrow
            assign full = (wgray == ~rgray_w);
        end
    endgenerate

    assign empty = (rgray == wgray_r);
    assign rdata = mem[rbin[AW-1:0]];
endmodule

// File: rtl/xb_host_port.sv
`timescale 1ns/1ps
module xb_host_port
    import xb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              stall,
    output logic              cmd_push,
    output cmd_t              cmd_word,
    input  logic              cmd_full,
    output logic              resp_pop,
    input  logic [DATA_W-1:0] resp_data,
    input  logic              resp_empty
);
    hstate_t st;

    // write access handler
    logic wr_req, wr_go;
    assign wr_req = (st == H_IDLE) && cs && we;
    assign wr_go  = wr_req && !cmd_full;

    // read access handler
    logic rd_req, rd_go;
    assign rd_req   = (st == H_IDLE) && cs && !we;
    assign rd_go    = rd_req && !cmd_full;
    assign resp_pop = (st == H_RDWAIT) && !resp_empty;

    assign cmd_push = wr_go || rd_go;
    assign cmd_word = make_cmd(we, addr, wdata);
    assign stall    = (st == H_RDWAIT) || rd_req || (wr_req && cmd_full);
    assign rvalid   = (st == H_RDDONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= H_IDLE;
            rdata <= '0;
        end else begin
            unique case (st)
                H_IDLE:   if (rd_go) st <= H_RDWAIT;
                H_RDWAIT: if (resp_pop) begin
                    rdata <= resp_data;
                    st    <= H_RDDONE;
                end
                H_RDDONE: st <= H_IDLE;
                default:  st <= H_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xb_core_port.sv
`timescale 1ns/1ps
module xb_core_port
    import xb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd_word,
    input  logic              cmd_empty,
    output logic              cmd_pop,
    output logic              resp_push,
    output logic [DATA_W-1:0] resp_data,
    input  logic              resp_full,
    output logic              c_wr,
    output logic              c_rd,
    output logic [ADDR_W-1:0] c_addr,
    output logic [DATA_W-1:0] c_wdata,
    input  logic [DATA_W-1:0] c_rdata
);
    cstate_t st;

    assign cmd_pop   = (st == C_IDLE) && !cmd_empty && !resp_full;
    assign resp_push = (st == C_RDCAP);
    assign resp_data = c_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= C_IDLE;
            c_wr    <= 1'b0;
            c_rd    <= 1'b0;
            c_addr  <= '0;
            c_wdata <= '0;
        end else begin
            c_wr <= 1'b0;
            c_rd <= 1'b0;
            unique case (st)
                C_IDLE: if (cmd_pop) begin
                    c_addr <= cmd_word.addr;
                    if (cmd_word.wr) begin
                        c_wr    <= 1'b1;
                        c_wdata <= cmd_word.data;
                    end else begin
                        c_rd <= 1'b1;
                        st   <= C_RDSTB;
                    end
                end
                C_RDSTB: st <= C_RDCAP;
                C_RDCAP: st <= C_IDLE;
                default: st <= C_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xdom_bus_bridge.sv
`timescale 1ns/1ps
module xdom_bus_bridge
    import xb_pkg::*;
#(
    parameter int FIFO_AW     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              h_clk,
    input  logic              h_rst,
    input  logic              h_cs,
    input  logic              h_we,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    output logic              h_rvalid,
    output logic              h_stall,
    input  logic              c_clk,
    input  logic              c_rst,
    output logic              c_wr,
    output logic              c_rd,
    output logic [ADDR_W-1:0] c_addr,
    output logic [DATA_W-1:0] c_wdata,
    input  logic [DATA_W-1:0] c_rdata
);
    logic h_rst_q, c_rst_q;
    logic any_rst;
    assign any_rst = h_rst | c_rst;

    xb_sync #(.W(1), .STAGES(SYNC_STAGES)) u_hrst (
        .clk(h_clk), .rst(1'b0), .d(any_rst), .q(h_rst_q)
    );
    xb_sync #(.W(1), .STAGES(SYNC_STAGES)) u_crst (
        .clk(c_clk), .rst(1'b0), .d(any_rst), .q(c_rst_q)
    );

    cmd_t              cmd_in, cmd_out;
    logic [CMD_W-1:0]  cmd_out_raw;
    logic              cmd_push, cmd_full, cmd_pop, cmd_empty;
    logic [DATA_W-1:0] resp_in, resp_out;
    logic              resp_push, resp_full, resp_pop, resp_empty;

    assign cmd_out = cmd_t'(cmd_out_raw);

    xb_host_port u_host (
        .clk(h_clk), .rst(h_rst_q),
        .cs(h_cs), .we(h_we), .addr(h_addr), .wdata(h_wdata),
        .rdata(h_rdata), .rvalid(h_rvalid), .stall(h_stall),
        .cmd_push(cmd_push), .cmd_word(cmd_in), .cmd_full(cmd_full),
        .resp_pop(resp_pop), .resp_data(resp_out), .resp_empty(resp_empty)
    );

    xb_afifo #(.W(CMD_W), .AW(FIFO_AW), .STAGES(SYNC_STAGES)) u_cmdq (
        .wclk(h_clk), .wrst(h_rst_q), .push(cmd_push), .wdata(cmd_in),
        .full(cmd_full),
        .rclk(c_clk), .rrst(c_rst_q), .pop(cmd_pop), .rdata(cmd_out_raw),
        .empty(cmd_empty)
    );

    xb_afifo #(.W(DATA_W), .AW(FIFO_AW), .STAGES(SYNC_STAGES)) u_respq (
        .wclk(c_clk), .wrst(c_rst_q), .push(resp_push), .wdata(resp_in),
        .full(resp_full),
        .rclk(h_clk), .rrst(h_rst_q), .pop(resp_pop), .rdata(resp_out),
        .empty(resp_empty)
    );

    xb_core_port u_core (
        .clk(c_clk), .rst(c_rst_q),
        .cmd_word(cmd_out), .cmd_empty(cmd_empty), .cmd_pop(cmd_pop),
        .resp_push(resp_push), .resp_data(resp_in), .resp_full(resp_full),
        .c_wr(c_wr), .c_rd(c_rd), .c_addr(c_addr), .c_wdata(c_wdata),
        .c_rdata(c_rdata)
    );
endmodule

// File: rtl/xb_checker.sv
`timescale 1ns/1ps
module xb_checker (
    input logic h_clk,
    input logic h_rst_q,
    input logic c_clk,
    input logic c_rst_q,
    input logic h_cs,
    input logic h_we,
    input logic h_stall,
    input logic h_rvalid,
    input logic cmd_push,
    input logic cmd_full,
    input logic resp_push,
    input logic resp_full,
    input logic c_wr,
    input logic c_rd
);
    // R5: strobes exclusive, read strobe single cycle
    a_r5_no_dual_strobe: assert property (@(posedge c_clk) disable iff (c_rst_q)
        !(c_wr && c_rd));
    a_r5_rd_one_cycle: assert property (@(posedge c_clk) disable iff (c_rst_q)
        c_rd |=> !c_rd);

    // R3: command queue never written while full
    a_r3_no_overflow: assert property (@(posedge h_clk) disable iff (h_rst_q)
        cmd_push |-> !cmd_full);

    // R8: single outstanding read keeps response queue from overflowing
    a_r8_resp_no_overflow: assert property (@(posedge c_clk) disable iff (c_rst_q)
        resp_push |-> !resp_full);
    a_r8_read_blocks: assert property (@(posedge h_clk) disable iff (h_rst_q)
        (h_cs && !h_we && !h_stall) |-> h_rvalid);

    // R4: completion pulse is one cycle and ends a stalled read
    a_r4_rvalid_pulse: assert property (@(posedge h_clk) disable iff (h_rst_q)
        h_rvalid |=> !h_rvalid);
    a_r4_rvalid_after_stall: assert property (@(posedge h_clk) disable iff (h_rst_q)
        h_rvalid |-> $past(h_stall));

    // R7: reset quiets both sides
    a_r7_core_quiet: assert property (@(posedge c_clk)
        c_rst_q |=> (!c_wr && !c_rd));
    a_r7_host_quiet: assert property (@(posedge h_clk)
        h_rst_q |=> !h_rvalid);
endmodule

bind xdom_bus_bridge xb_checker u_chk (
    .h_clk(h_clk), .h_rst_q(h_rst_q), .c_clk(c_clk), .c_rst_q(c_rst_q),
    .h_cs(h_cs), .h_we(h_we), .h_stall(h_stall), .h_rvalid(h_rvalid),
    .cmd_push(cmd_push), .cmd_full(cmd_full),
    .resp_push(resp_push), .resp_full(resp_full),
    .c_wr(c_wr), .c_rd(c_rd)
);

// File: tb/sim_xdom_bus_bridge.sv
`timescale 1ns/1ps
module sim_xdom_bus_bridge;

    logic h_clk = 1'b0, c_clk = 1'b0;
    bit   h_run = 1'b1, c_run = 1'b1;
    logic h_rst = 1'b1, c_rst = 1'b1;
    logic h_cs = 1'b0, h_we = 1'b0;
    logic [15:0] h_addr = '0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic h_rvalid, h_stall;
    logic c_wr, c_rd;
    logic [15:0] c_addr;
    logic [31:0] c_wdata;
    logic [31:0] c_rdata = '0;

    always begin #3.75; if (h_run) h_clk = ~h_clk; end
    always begin #10;   if (c_run) c_clk = ~c_clk; end

    xdom_bus_bridge u0 (
        .h_clk(h_clk), .h_rst(h_rst), .h_cs(h_cs), .h_we(h_we),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .h_rvalid(h_rvalid), .h_stall(h_stall),
        .c_clk(c_clk), .c_rst(c_rst), .c_wr(c_wr), .c_rd(c_rd),
        .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata)
    );

    int n_cmp = 0, n_bad = 0;
    int n_wr_seen = 0, n_rd_seen = 0;
    bit prev_rd = 1'b0;
    bit done = 1'b0;
    logic [31:0] shadow   [256];
    logic [31:0] core_mem [256];
    logic [47:0] exp_wq [$];

    function automatic logic [31:0] seed_val(input int i);
        return 32'hC0DE_0000 ^ (32'(i) * 32'h0101_0107);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // core-side model: memory with one-cycle read latency
    always @(negedge c_clk) begin
        if (c_wr) begin
            n_wr_seen++;
            if (exp_wq.size() == 0) begin
                chk(1'b0, "R1", "unexpected core write", {c_addr, c_wdata}, 48'h0);
            end else begin
                logic [47:0] e;
                e = exp_wq.pop_front();
                chk({c_addr, c_wdata} == e, "R1", "core write addr/data", {c_addr, c_wdata}, e);
            end
            core_mem[c_addr[7:0]] = c_wdata;
        end
        if (c_rd) begin
            n_rd_seen++;
            c_rdata = core_mem[c_addr[7:0]];
        end
        if (c_wr || c_rd || prev_rd)
            chk(!(c_wr && c_rd) && !(prev_rd && c_rd), "R5", "strobe shape",
                {46'h0, c_wr, c_rd}, {46'h0, 2'b00});
        prev_rd = c_rd;
    end

    task automatic host_write(input logic [15:0] a, input logic [31:0] d,
                              output int stalls);
        stalls = 0;
        @(negedge h_clk);
        h_cs = 1'b1; h_we = 1'b1; h_addr = a; h_wdata = d;
        forever begin
            #0.5;
            if (!h_stall) break;
            stalls++;
            @(negedge h_clk);
        end
        shadow[a[7:0]] = d;
        exp_wq.push_back({a, d});
        @(posedge h_clk);
        #0.5;
        h_cs = 1'b0; h_we = 1'b0;
    endtask

    task automatic host_read(input logic [15:0] a, output logic [31:0] d);
        int rd_before;
        rd_before = n_rd_seen;
        @(negedge h_clk);
        h_cs = 1'b1; h_we = 1'b0; h_addr = a;
        forever begin
            #0.5;
            if (h_rvalid) break;
            if (!h_stall) chk(1'b0, "R4", "stall dropped before result", 48'h0, 48'h1);
            @(negedge h_clk);
        end
        d = h_rdata;
        @(posedge h_clk);
        #0.5;
        h_cs = 1'b0;
        chk(!h_rvalid, "R4", "rvalid single cycle", {47'h0, h_rvalid}, 48'h0);
        chk(n_rd_seen - rd_before == 1, "R8", "core reads per host read",
            48'(n_rd_seen - rd_before), 48'h1);
    endtask

    task automatic read_check(input logic [15:0] a, input string req);
        logic [31:0] got;
        host_read(a, got);
        chk(got == shadow[a[7:0]], req, "read data", {16'h0, got}, {16'h0, shadow[a[7:0]]});
    endtask

    task automatic do_reset();
        @(negedge h_clk);
        h_rst = 1'b1; c_rst = 1'b1;
        repeat (12) @(posedge c_clk);
        @(negedge c_clk);
        h_rst = 1'b0; c_rst = 1'b0;
        repeat (6) @(posedge c_clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int s;
        int wr_mark;
        logic [31:0] sv0, sv1;
        for (int i = 0; i < 256; i++) begin
            shadow[i]   = seed_val(i);
            core_mem[i] = seed_val(i);
        end
        void'($urandom(32'h5EED));
        do_reset();

        // R7: idle outputs after reset
        @(negedge c_clk);
        chk({h_stall, h_rvalid, c_wr, c_rd} == 4'b0, "R7", "idle after reset",
            {44'h0, h_stall, h_rvalid, c_wr, c_rd}, 48'h0);

        // directed basics
        host_write(16'h1010, 32'hDEAD_BEEF, s);
        read_check(16'h1010, "R4");
        read_check(16'h7720, "R4");
        host_write(16'h0033, 32'h1234_5678, s);
        host_write(16'h0033, 32'h8765_4321, s);
        read_check(16'h0033, "R2");

        // R3: fill the command FIFO with the core clock held
        repeat (4) @(posedge c_clk);
        @(negedge c_clk); c_run = 1'b0;
        wr_mark = n_wr_seen;
        for (int i = 0; i < 4; i++) begin
            host_write(16'h0040 + 16'(i), 32'hA000_0000 + 32'(i), s);
            chk(s == 0, "R3", "no stall below full", 48'(s), 48'h0);
        end
        @(negedge h_clk);
        h_cs = 1'b1; h_we = 1'b1; h_addr = 16'h0044; h_wdata = 32'hA000_0004;
        #0.5;
        chk(h_stall == 1'b1, "R3", "stall when full", {47'h0, h_stall}, 48'h1);
        repeat (6) @(negedge h_clk);
        #0.5;
        chk(h_stall == 1'b1, "R3", "write held while full", {47'h0, h_stall}, 48'h1);
        chk(n_wr_seen == wr_mark, "R3", "nothing drained", 48'(n_wr_seen), 48'(wr_mark));
        c_run = 1'b1;
        while (h_stall) begin @(negedge h_clk); #0.5; end
        shadow[8'h44] = 32'hA000_0004;
        exp_wq.push_back({16'h0044, 32'hA000_0004});
        @(posedge h_clk); #0.5; h_cs = 1'b0;
        repeat (30) @(posedge c_clk);
        chk(n_wr_seen == wr_mark + 5, "R3", "all five writes once",
            48'(n_wr_seen), 48'(wr_mark + 5));
        chk(exp_wq.size() == 0, "R2", "queue drained in order", 48'(exp_wq.size()), 48'h0);

        // R6: host clock stopped, core drains
        @(negedge c_clk); c_run = 1'b0;
        wr_mark = n_wr_seen;
        for (int i = 0; i < 3; i++) host_write(16'h0050 + 16'(i), 32'hB000_0000 + 32'(i), s);
        @(negedge h_clk); h_run = 1'b0;
        c_run = 1'b1;
        repeat (30) @(posedge c_clk);
        chk(n_wr_seen == wr_mark + 3, "R6", "drain with host clock stopped",
            48'(n_wr_seen), 48'(wr_mark + 3));
        h_run = 1'b1;
        read_check(16'h0052, "R6");

        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [15:0] a;
            a = {8'($urandom), 4'h0, 4'($urandom)};
            if (($urandom % 10) < 6) host_write(a, $urandom, s);
            else read_check(a, "R2");
            repeat ($urandom % 3) @(negedge h_clk);
        end
        repeat (30) @(posedge c_clk);
        chk(exp_wq.size() == 0, "R1", "random writes all executed", 48'(exp_wq.size()), 48'h0);

        // R7: reset with queued commands
        @(negedge c_clk); c_run = 1'b0;
        sv0 = shadow[8'h60]; sv1 = shadow[8'h61];
        host_write(16'h0060, 32'hBAD0_0000, s);
        host_write(16'h0061, 32'hBAD0_0001, s);
        exp_wq.delete();
        shadow[8'h60] = sv0; shadow[8'h61] = sv1;
        wr_mark = n_wr_seen;
        @(negedge h_clk);
        h_rst = 1'b1; c_rst = 1'b1;
        repeat (6) @(posedge h_clk);
        c_run = 1'b1;
        repeat (10) @(posedge c_clk);
        @(negedge c_clk);
        h_rst = 1'b0; c_rst = 1'b0;
        repeat (40) @(posedge c_clk);
        @(negedge c_clk);
        chk(n_wr_seen == wr_mark, "R7", "stale writes executed", 48'(n_wr_seen), 48'(wr_mark));
        chk({h_stall, h_rvalid, c_wr, c_rd} == 4'b0, "R7", "idle after second reset",
            {44'h0, h_stall, h_rvalid, c_wr, c_rd}, 48'h0);
        read_check(16'h0060, "R7");
        host_write(16'h0061, 32'h600D_0001, s);
        read_check(16'h0061, "R7");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule